// File: doc/BRIEF.md
# Serial Peripheral Chip-Select Controller

This block owns the chip-select lines of a serial peripheral master. A host writes one control word that carries a per-line select mask, a polarity bit and a mode bit, and can read that word back. The shift engine, clock generation and data path sit outside. They talk to this block through two one-cycle pulses: one marks the start of a transfer and one marks its completion.

In manual mode the select lines follow the mask as soon as the write lands. In auto mode a mask bit only marks which line belongs to the next transfer. That line is driven active from the cycle in which the start pulse is seen, through the cycle of the done pulse, and is inactive otherwise.

Polarity is programmable in both modes. If software sets more than one mask bit, only the lowest-numbered line is driven, and a sticky error flag records the mistake. A control write that arrives while an auto transfer is running is parked. It takes effect at the transfer's done pulse.

Top module: `spi_sel_ctrl`

## Requirements
- R1: After reset the read word is 0, the error flag is 0, and every select line is driven high, which is the inactive level for the default active-low setting.
- R2: The read word carries the mask in bits [1:0], the level bit in bit 2, the auto bit in bit 3 and the error flag in bit 4. Bits [31:5] always read 0, whatever was written to them.
- R3: With auto = 0, a line whose lowest-selected mask bit is 1 is driven active from the cycle after the write. A mask bit of 0 drives its line inactive. The lines hold until the next write.
- R4: Level bit = 0 makes active mean low; level bit = 1 makes active mean high. Inactive is the opposite level. This holds in both modes.
- R5: With auto = 1, every select line is inactive in any cycle where no transfer is running and no start pulse is present.
- R6: With auto = 1, the selected line goes active in the same cycle as the start pulse.
- R7: In auto mode the selected line stays active through the cycle of the done pulse and is inactive from the next cycle on.
- R8: When the mask has more than one bit set, only the lowest-numbered selected line is ever driven active.
- R9: A committed mask with more than one bit set sets the error flag. Once set, the flag stays 1 until reset.
- R10: A control write made while an auto transfer is running, including in its start cycle, does not change the lines or the readback until the done pulse. From the cycle after the done pulse the last such write is in effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Control-word write strobe |
| wr_data | input | 32 | Control word to write |
| rd_data | output | 32 | Control word readback with error flag |
| xfer_start | input | 1 | One-cycle transfer start pulse from the shift engine |
| xfer_done | input | 1 | One-cycle transfer completion pulse from the shift engine |
| sel_o | output | 2 | Chip-select lines, polarity set by the level bit |

## Verification
The bench builds the block with its default two select lines and a 32-bit control word. With that setting every mask value can be tried, including the double-select case that drives the priority pick and the error flag. A behavioural model predicts the lines and the readback every cycle. It covers writes parked inside an auto transfer and transfers run at both polarities.

// File: rtl/spi_sel_pkg.sv
package spi_sel_pkg;
  // control word layout offsets relative to the mask width
  localparam int unsigned LVL_OFS  = 0;
  localparam int unsigned AUTO_OFS = 1;
  localparam int unsigned ERR_OFS  = 2;
endpackage

// File: rtl/sel_cfg_reg.sv
module sel_cfg_reg #(
  parameter int unsigned NSEL = 2,
  parameter int unsigned DW   = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [DW-1:0]   wr_data,
  input  logic            hold,
  input  logic            done_evt,
  output logic [NSEL-1:0] cfg_mask,
  output logic            cfg_lvl,
  output logic            cfg_auto,
  output logic            cfg_err,
  output logic            commit_en
);
  import spi_sel_pkg::*;
  localparam int unsigned FW = NSEL + 2;

  function automatic logic multi_sel(input logic [NSEL-1:0] v);
    return (v & (v - {{(NSEL-1){1'b0}}, 1'b1})) != '0;
  endfunction

  logic [FW-1:0] pend_q;
  logic          pend_v;
  logic [FW-1:0] wr_fields;
  logic [FW-1:0] commit_val;

  assign wr_fields  = wr_data[FW-1:0];
  assign commit_en  = !hold && (wr_en || (done_evt && pend_v));
  assign commit_val = wr_en ? wr_fields : pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q   <= '0;
      pend_v   <= 1'b0;
      cfg_mask <= '0;
      cfg_lvl  <= 1'b0;
      cfg_auto <= 1'b0;
      cfg_err  <= 1'b0;
    end else begin
      if (hold && wr_en) begin
        pend_q <= wr_fields;
        pend_v <= 1'b1;
      end else if (!hold) begin
        pend_v <= 1'b0;
      end
      if (commit_en) begin
        cfg_mask <= commit_val[NSEL-1:0];
        cfg_lvl  <= commit_val[NSEL+LVL_OFS];
        cfg_auto <= commit_val[NSEL+AUTO_OFS];
        if (multi_sel(commit_val[NSEL-1:0])) cfg_err <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/sel_frame.sv
module sel_frame (
  input  logic clk,
  input  logic rst_n,
  input  logic cfg_auto,
  input  logic xfer_start,
  input  logic xfer_done,
  output logic start_evt,
  output logic done_evt,
  output logic in_xfer,
  output logic xfer_active,
  output logic hold
);
  assign start_evt   = cfg_auto && xfer_start && !in_xfer;
  assign done_evt    = in_xfer && xfer_done;
  assign xfer_active = in_xfer || start_evt;
  assign hold        = xfer_active && !done_evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         in_xfer <= 1'b0;
    else if (done_evt)  in_xfer <= 1'b0;
    else if (start_evt) in_xfer <= 1'b1;
  end
endmodule

// File: rtl/sel_drive.sv
module sel_drive #(
  parameter int unsigned NSEL = 2
) (
  input  logic [NSEL-1:0] mask,
  input  logic            lvl,
  input  logic            enable,
  output logic [NSEL-1:0] sel_o
);
  function automatic logic [NSEL-1:0] lowest_one(input logic [NSEL-1:0] v);
    return v & (~v + {{(NSEL-1){1'b0}}, 1'b1});
  endfunction

  logic [NSEL-1:0] pick;
  assign pick = lowest_one(mask);

  for (genvar i = 0; i < NSEL; i++) begin : g_line
    assign sel_o[i] = (enable && pick[i]) ? lvl : !lvl;
  end
endmodule

// File: rtl/spi_sel_ctrl.sv
module spi_sel_ctrl #(
  parameter int unsigned NSEL = 2,
  parameter int unsigned DW   = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [DW-1:0]   wr_data,
  output logic [DW-1:0]   rd_data,
  input  logic            xfer_start,
  input  logic            xfer_done,
  output logic [NSEL-1:0] sel_o
);
  import spi_sel_pkg::*;

  logic [NSEL-1:0] cfg_mask;
  logic            cfg_lvl, cfg_auto, cfg_err, commit_en;
  logic            start_evt, done_evt, in_xfer, xfer_active, hold;
  logic            drive_en;

  sel_frame u_frame (
    .clk(clk), .rst_n(rst_n), .cfg_auto(cfg_auto),
    .xfer_start(xfer_start), .xfer_done(xfer_done),
    .start_evt(start_evt), .done_evt(done_evt), .in_xfer(in_xfer),
    .xfer_active(xfer_active), .hold(hold)
  );

  sel_cfg_reg #(.NSEL(NSEL), .DW(DW)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .hold(hold), .done_evt(done_evt),
    .cfg_mask(cfg_mask), .cfg_lvl(cfg_lvl), .cfg_auto(cfg_auto),
    .cfg_err(cfg_err), .commit_en(commit_en)
  );

  assign drive_en = !cfg_auto || xfer_active;

  sel_drive #(.NSEL(NSEL)) u_drive (
    .mask(cfg_mask), .lvl(cfg_lvl), .enable(drive_en), .sel_o(sel_o)
  );

  always_comb begin
    rd_data = '0;
    rd_data[NSEL-1:0]      = cfg_mask;
    rd_data[NSEL+LVL_OFS]  = cfg_lvl;
    rd_data[NSEL+AUTO_OFS] = cfg_auto;
    rd_data[NSEL+ERR_OFS]  = cfg_err;
  end
endmodule

// File: rtl/spi_sel_ctrl_chk.sv
module spi_sel_ctrl_chk #(
  parameter int unsigned NSEL = 2,
  parameter int unsigned DW   = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NSEL-1:0] sel_o,
  input logic [DW-1:0]   rd_data,
  input logic            cfg_auto,
  input logic            cfg_lvl,
  input logic            cfg_err,
  input logic            xfer_active,
  input logic            done_evt,
  input logic            in_xfer,
  input logic            hold
);
  // R5
  idle_inactive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_auto && !xfer_active) |-> (sel_o == {NSEL{!cfg_lvl}}));
  // R8
  single_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sel_o ^ {NSEL{!cfg_lvl}}));
  // R9
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |=> cfg_err);
  // R7
  done_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt |=> !in_xfer);
  // R2
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[DW-1:NSEL+3] == '0);
  // R10
  held_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> $stable(rd_data[NSEL+1:0]));
endmodule

bind spi_sel_ctrl spi_sel_ctrl_chk #(.NSEL(NSEL), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .sel_o(sel_o), .rd_data(rd_data),
  .cfg_auto(cfg_auto), .cfg_lvl(cfg_lvl), .cfg_err(cfg_err),
  .xfer_active(xfer_active), .done_evt(done_evt), .in_xfer(in_xfer),
  .hold(hold)
);

// File: tb/spi_sel_ctrl_tb.sv
`timescale 1ns/1ps
module spi_sel_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        xfer_start = 1'b0;
  logic        xfer_done = 1'b0;
  logic [1:0]  sel_o;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  spi_sel_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .xfer_start(xfer_start), .xfer_done(xfer_done),
    .sel_o(sel_o)
  );

  // reference model state
  int m_mask = 0, m_lvl = 0, m_auto = 0, m_err = 0, m_busy = 0;
  int m_pv = 0, m_pend = 0;

  function automatic int low_idx(input int mask);
    for (int i = 0; i < 2; i++) if ((mask >> i) & 1) return i;
    return -1;
  endfunction

  function automatic int bits_set(input int mask);
    int n = 0;
    for (int i = 0; i < 2; i++) n += (mask >> i) & 1;
    return n;
  endfunction

  task automatic compare(input string req, input bit st);
    int on, li;
    logic [1:0] exp_sel;
    logic [31:0] exp_rd;
    on = (m_auto == 0) || (m_busy != 0) || (st && m_busy == 0);
    li = low_idx(m_mask);
    for (int i = 0; i < 2; i++)
      exp_sel[i] = (on != 0 && li == i) ? m_lvl[0] : !m_lvl[0];
    exp_rd = 32'(m_mask) | (32'(m_lvl) << 2) | (32'(m_auto) << 3) | (32'(m_err) << 4);
    checks++;
    if (sel_o !== exp_sel) begin
      errors++;
      $display("FAIL %s sel_o actual %b expected %b", req, sel_o, exp_sel);
    end
    checks++;
    if (rd_data !== exp_rd) begin
      errors++;
      $display("FAIL %s rd_data actual %h expected %h", req, rd_data, exp_rd);
    end
  endtask

  task automatic step(input bit wr, input logic [31:0] d, input bit st,
                      input bit dn, input string req);
    int startev, doneev, hold, v;
    wr_en = wr; wr_data = d; xfer_start = st; xfer_done = dn;
    @(negedge clk);
    compare(req, st);
    @(posedge clk);
    doneev  = (m_busy != 0) && dn;
    startev = (m_auto != 0) && st && (m_busy == 0);
    hold    = ((m_busy != 0) || startev != 0) && !doneev;
    if (hold) begin
      if (wr) begin m_pend = int'(d[3:0]); m_pv = 1; end
    end else begin
      if (wr || (doneev && m_pv)) begin
        v = wr ? int'(d[3:0]) : m_pend;
        m_mask = v & 3; m_lvl = (v >> 2) & 1; m_auto = (v >> 3) & 1;
        if (bits_set(m_mask) > 1) m_err = 1;
      end
      m_pv = 0;
    end
    if (doneev) m_busy = 0;
    else if (startev) m_busy = 1;
    #1;
    wr_en = 0; xfer_start = 0; xfer_done = 0;
  endtask

  task automatic idle(input int n, input string req);
    for (int i = 0; i < n; i++) step(0, '0, 0, 0, req);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    idle(2, "R1");
    // manual mode
    step(1, 32'h1, 0, 0, "R3"); idle(2, "R3");
    step(1, 32'h2, 0, 0, "R3"); idle(1, "R3");
    step(1, 32'h0, 0, 0, "R3"); idle(1, "R3");
    step(1, 32'hFFFF_FFE2, 0, 0, "R2"); idle(1, "R2");
    step(1, 32'h5, 0, 0, "R4"); idle(1, "R4");
    step(1, 32'h6, 0, 0, "R4"); idle(1, "R4");
    // auto mode, active low, line 1
    step(1, 32'hA, 0, 0, "R5"); idle(3, "R5");
    step(0, '0, 1, 0, "R6"); idle(2, "R6");
    step(1, 32'h9, 0, 0, "R10"); idle(2, "R10");
    step(0, '0, 0, 1, "R7"); idle(2, "R10");
    // auto mode, active high, line 0
    step(1, 32'hD, 0, 0, "R4"); idle(1, "R5");
    step(1, 32'h1, 1, 0, "R10"); idle(1, "R6");
    step(0, '0, 0, 1, "R7"); idle(2, "R10");
    // back to auto, start after one idle
    step(1, 32'hE, 0, 0, "R5"); idle(1, "R5");
    step(0, '0, 1, 0, "R6");
    step(0, '0, 0, 1, "R7"); idle(1, "R7");
    step(0, '0, 1, 0, "R6");
    step(0, '0, 0, 1, "R7"); idle(1, "R7");
    // multiple lines selected
    step(1, 32'h3, 0, 0, "R8"); idle(2, "R9");
    step(1, 32'hF, 0, 0, "R8"); idle(1, "R8");
    step(0, '0, 1, 0, "R8"); idle(1, "R8");
    step(0, '0, 0, 1, "R8"); idle(1, "R9");
    step(1, 32'h2, 0, 0, "R9"); idle(2, "R9");
    // reset clears error and fields
    rst_n = 1'b0; @(posedge clk); #1 rst_n = 1'b1;
    m_mask = 0; m_lvl = 0; m_auto = 0; m_err = 0; m_busy = 0; m_pv = 0;
    idle(2, "R1");
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule